// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block keeps the per-source state for a configurable number of interrupt lines. For each line it holds an enable bit, a pending bit, an active bit, a group bit, an 8-bit priority, an 8-bit CPU target mask and a 2-bit trigger field. Software reaches all of this through a 32-bit register port. Writes take effect on the clock edge. Reads are combinational from the read address. The enable, pending and active bits each have a pair of windows: a 1 written to the set window turns a bit on, and a 1 written to the clear window turns it off.

The bank samples the incoming lines every cycle. A line set to edge mode latches pending on a rising edge. A line set to level mode shows as pending while its input is high and the line is not active. A single arbiter serves one CPU interface. It names the enabled, pending and non-active line whose priority value is numerically lowest, and when two lines share that value it takes the lower ID. The CPU interface returns acknowledge and end-of-interrupt events, which move a line from pending to active and from active back to inactive.

Top module: `irq_dist_bank`

## Requirements
- R1: After reset the following all read as zero: every enable, pending, active and group bit, every priority and target byte, the trigger fields of IDs 16 and up, and the control word. The best-candidate output is not valid.
- R2: Writing 1 to a bit in the set-enable window (0x100 + 4·(id/32)) sets that enable bit, and writing 1 to the same bit in the clear-enable window (0x180 + ...) clears it. Writing 0 changes nothing. Both windows read back the current enable bits, with ID id at bit id mod 32.
- R3: The pending windows (set 0x200, clear 0x280) and the active windows (set 0x300, clear 0x380) follow the same set/clear rule as R2 and read back the current state. The group window at 0x080 is a plain read/write bit per ID.
- R4: Priority (0x400 + 4·(id/4)) and target (0x800 + 4·(id/4)) hold one byte per ID, with ID id in byte lane id mod 4 (lane 0 = bits 7:0). They read back what was written.
- R5: The trigger field at 0xC00 + 4·(id/16) is 2 bits per ID, at bits 2·(id mod 16)+1:2·(id mod 16). Its upper bit set to 1 selects edge mode and set to 0 selects level mode. IDs 0 to 15 are fixed at 2'b10 (edge) and ignore writes.
- R6: The type word at 0x004 reads NUM_IRQ/32 − 1 in bits 4:0 and zero elsewhere.
- R7: Control bit 0 at 0x000 enables forwarding. While it is 0 the best-candidate output stays not valid.
- R8: An edge-mode line sets pending one cycle after its input rises. Pending then stays set after the input falls, until a clear or an acknowledge.
- R9: A level-mode line reads as pending while its sampled input is high and the line is not active. It stops reading as pending when the input falls or the line is acknowledged, and it reads as pending again after end-of-interrupt if the input is still high.
- R10: One cycle after the state settles, the best-candidate output gives the ID and priority of the enabled, pending, non-active line with the lowest priority value. Ties go to the lowest ID.
- R11: An acknowledge event for an ID clears its pending latch and sets its active bit, which removes the line from arbitration.
- R12: An end-of-interrupt event for an ID clears its active bit.
- R13: Writes and reads whose address bits 1:0 are non-zero are ignored or read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read byte address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq_in | input | NUM_IRQ | Incoming interrupt lines |
| ack_valid | input | 1 | Acknowledge event from the CPU interface |
| ack_id | input | $clog2(NUM_IRQ) | ID being acknowledged |
| eoi_valid | input | 1 | End-of-interrupt event from the CPU interface |
| eoi_id | input | $clog2(NUM_IRQ) | ID being completed |
| best_valid | output | 1 | A candidate exists and forwarding is on |
| best_id | output | $clog2(NUM_IRQ) | ID of the selected candidate (0 when not valid) |
| best_prio | output | 8 | Priority of the selected candidate (0 when not valid) |

## Verification
The hardest situation to reach is a level-mode line that is acknowledged while its input is still high. Its pending state then has to disappear because of the active bit, not because of the latch, and it has to come back at end-of-interrupt. The stimulus holds the line high across both an acknowledge and an end-of-interrupt. It reads the pending and active windows between the two events, and it watches the arbiter fall back to the next candidate and then return. Ties are set up by giving two lines the same priority byte within one register word. A set-active write is used to force the tie winner out, which shows the arbiter falling through to a higher-valued priority.

// File: rtl/irq_dist_pkg.sv
`timescale 1ns/1ps
package irq_dist_pkg;

   localparam int ADDR_W = 12;
   localparam int DATA_W = 32;
   localparam int MAX_IRQ = 992;

   // bit windows, decoded from address bits 11:7 when bits 11:10 are zero
   typedef enum logic [4:0] {
      WIN_CTRL     = 5'h00,
      WIN_GROUP    = 5'h01,
      WIN_EN_SET   = 5'h02,
      WIN_EN_CLR   = 5'h03,
      WIN_PEND_SET = 5'h04,
      WIN_PEND_CLR = 5'h05,
      WIN_ACT_SET  = 5'h06,
      WIN_ACT_CLR  = 5'h07
   } bit_win_e;

   // regions decoded from address bits 11:10
   localparam logic [1:0] REGION_BITS = 2'b00;
   localparam logic [1:0] REGION_PRIO = 2'b01;
   localparam logic [1:0] REGION_TGT  = 2'b10;
   localparam logic [1:0] REGION_CFG  = 2'b11;

   localparam logic [1:0] CFG_FIXED_EDGE = 2'b10;
   localparam int         FIXED_CFG_IDS  = 16;

endpackage

// File: rtl/irq_dist_cell.sv
`timescale 1ns/1ps
module irq_dist_cell (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_set,
   input  logic       en_clr,
   input  logic       pend_set,
   input  logic       pend_clr,
   input  logic       act_set,
   input  logic       act_clr,
   input  logic       grp_we,
   input  logic       grp_d,
   input  logic       prio_we,
   input  logic [7:0] prio_d,
   input  logic       tgt_we,
   input  logic [7:0] tgt_d,
   input  logic       line_in,
   input  logic       edge_mode,
   input  logic       ack_hit,
   input  logic       eoi_hit,
   output logic       en,
   output logic       pend,
   output logic       act,
   output logic       grp,
   output logic [7:0] prio,
   output logic [7:0] tgt
);

   logic en_q, pend_q, act_q, grp_q, line_q;
   logic [7:0] prio_q, tgt_q;
   logic rise;

   assign rise = line_in & ~line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         pend_q <= 1'b0;
         act_q  <= 1'b0;
         grp_q  <= 1'b0;
         line_q <= 1'b0;
         prio_q <= '0;
         tgt_q  <= '0;
      end else begin
         line_q <= line_in;
         en_q   <= (en_q & ~en_clr) | en_set;
         // new edges and software sets win over clears in the same cycle
         pend_q <= (pend_q & ~pend_clr & ~ack_hit) | pend_set | (edge_mode & rise);
         // acknowledge wins over completion in the same cycle
         act_q  <= (act_q & ~act_clr & ~eoi_hit) | act_set | ack_hit;
         if (grp_we)  grp_q  <= grp_d;
         if (prio_we) prio_q <= prio_d;
         if (tgt_we)  tgt_q  <= tgt_d;
      end
   end

   assign en   = en_q;
   assign act  = act_q;
   assign grp  = grp_q;
   assign prio = prio_q;
   assign tgt  = tgt_q;
   assign pend = pend_q | (~edge_mode & line_q & ~act_q);

endmodule

// File: rtl/irq_dist_arb.sv
`timescale 1ns/1ps
module irq_dist_arb #(
   parameter int NUM_IRQ = 64,
   localparam int ID_W = $clog2(NUM_IRQ)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   fwd_en,
   input  logic [NUM_IRQ-1:0]     cand,
   input  logic [8*NUM_IRQ-1:0]   prio_flat,
   output logic                   best_valid,
   output logic [ID_W-1:0]        best_id,
   output logic [7:0]             best_prio
);

   logic            found;
   logic [ID_W-1:0] win_id;
   logic [7:0]      win_prio;

   // ascending scan with strict compare keeps the lowest ID on a tie
   always_comb begin
      found    = 1'b0;
      win_id   = '0;
      win_prio = '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (cand[i] && (!found || (prio_flat[8*i +: 8] < win_prio))) begin
            found    = 1'b1;
            win_id   = ID_W'(i);
            win_prio = prio_flat[8*i +: 8];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_valid <= 1'b0;
         best_id    <= '0;
         best_prio  <= '0;
      end else begin
         best_valid <= found & fwd_en;
         best_id    <= (found & fwd_en) ? win_id : '0;
         best_prio  <= (found & fwd_en) ? win_prio : '0;
      end
   end

endmodule

// File: rtl/irq_dist_bank.sv
`timescale 1ns/1ps
module irq_dist_bank
   import irq_dist_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   localparam int ID_W = $clog2(NUM_IRQ)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [11:0]          wr_addr,
   input  logic [31:0]          wr_data,
   input  logic [11:0]          rd_addr,
   output logic [31:0]          rd_data,
   input  logic [NUM_IRQ-1:0]   irq_in,
   input  logic                 ack_valid,
   input  logic [ID_W-1:0]      ack_id,
   input  logic                 eoi_valid,
   input  logic [ID_W-1:0]      eoi_id,
   output logic                 best_valid,
   output logic [ID_W-1:0]      best_id,
   output logic [7:0]           best_prio
);

   localparam int NUM_BIT_WORDS  = NUM_IRQ / 32;
   localparam int NUM_BYTE_WORDS = NUM_IRQ / 4;
   localparam int NUM_CFG_WORDS  = NUM_IRQ / 16;
   localparam logic [31:0] TYPE_WORD = 32'(NUM_BIT_WORDS - 1);

   if (NUM_IRQ < 32 || (NUM_IRQ % 32) != 0 || NUM_IRQ > MAX_IRQ) begin : g_bad_num_irq
      $error("NUM_IRQ must be a multiple of 32 between 32 and %0d", MAX_IRQ);
   end

   logic                 fwd_en;
   logic [NUM_IRQ-1:0]   en_v, pend_v, act_v, grp_v, edge_v, cand_v;
   logic [8*NUM_IRQ-1:0] prio_flat, tgt_flat;
   logic [2*NUM_IRQ-1:0] cfg_flat;

   logic       wr_ok;
   logic [4:0] wr_win;
   logic [4:0] wr_bword;
   logic [7:0] wr_lword;

   assign wr_ok    = wr_en && (wr_addr[1:0] == 2'b00);
   assign wr_win   = wr_addr[11:7];
   assign wr_bword = wr_addr[6:2];
   assign wr_lword = wr_addr[9:2];

   // forwarding control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fwd_en <= 1'b0;
      else if (wr_ok && wr_addr[11:10] == REGION_BITS && wr_win == WIN_CTRL && wr_bword == 5'd0)
         fwd_en <= wr_data[0];
   end

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
      localparam logic [4:0] BWI = 5'(i / 32);
      localparam int         BBI = i % 32;
      localparam logic [7:0] LWI = 8'(i / 4);
      localparam int         LBI = i % 4;
      localparam logic [7:0] CWI = 8'(i / 16);
      localparam int         CBI = i % 16;

      logic word_hit, one_bit, lane_hit;

      assign word_hit = wr_ok && (wr_addr[11:10] == REGION_BITS) && (wr_bword == BWI);
      assign one_bit  = wr_data[BBI];
      assign lane_hit = wr_ok && (wr_lword == LWI);

      irq_dist_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .en_set    (word_hit && one_bit && wr_win == WIN_EN_SET),
         .en_clr    (word_hit && one_bit && wr_win == WIN_EN_CLR),
         .pend_set  (word_hit && one_bit && wr_win == WIN_PEND_SET),
         .pend_clr  (word_hit && one_bit && wr_win == WIN_PEND_CLR),
         .act_set   (word_hit && one_bit && wr_win == WIN_ACT_SET),
         .act_clr   (word_hit && one_bit && wr_win == WIN_ACT_CLR),
         .grp_we    (word_hit && wr_win == WIN_GROUP),
         .grp_d     (one_bit),
         .prio_we   (lane_hit && wr_addr[11:10] == REGION_PRIO),
         .prio_d    (wr_data[8*LBI +: 8]),
         .tgt_we    (lane_hit && wr_addr[11:10] == REGION_TGT),
         .tgt_d     (wr_data[8*LBI +: 8]),
         .line_in   (irq_in[i]),
         .edge_mode (edge_v[i]),
         .ack_hit   (ack_valid && ack_id == ID_W'(i)),
         .eoi_hit   (eoi_valid && eoi_id == ID_W'(i)),
         .en        (en_v[i]),
         .pend      (pend_v[i]),
         .act       (act_v[i]),
         .grp       (grp_v[i]),
         .prio      (prio_flat[8*i +: 8]),
         .tgt       (tgt_flat[8*i +: 8])
      );

      if (i < FIXED_CFG_IDS) begin : g_cfg_fixed
         assign cfg_flat[2*i +: 2] = CFG_FIXED_EDGE;
      end else begin : g_cfg_prog
         logic [1:0] cfg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cfg_q <= 2'b00;
            else if (wr_ok && wr_addr[11:10] == REGION_CFG && wr_lword == CWI)
               cfg_q <= wr_data[2*CBI +: 2];
         end
         assign cfg_flat[2*i +: 2] = cfg_q;
      end

      assign edge_v[i] = cfg_flat[2*i + 1];
   end

   assign cand_v = en_v & pend_v & ~act_v;

   irq_dist_arb #(.NUM_IRQ(NUM_IRQ)) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .fwd_en     (fwd_en),
      .cand       (cand_v),
      .prio_flat  (prio_flat),
      .best_valid (best_valid),
      .best_id    (best_id),
      .best_prio  (best_prio)
   );

   // read side
   function automatic logic [31:0] bit_word(input logic [NUM_IRQ-1:0] v, input logic [4:0] w);
      logic [31:0] r;
      r = '0;
      for (int k = 0; k < NUM_BIT_WORDS; k++)
         if (w == 5'(k)) r = v[32*k +: 32];
      return r;
   endfunction

   function automatic logic [31:0] byte_word(input logic [8*NUM_IRQ-1:0] v, input logic [7:0] w);
      logic [31:0] r;
      r = '0;
      for (int k = 0; k < NUM_BYTE_WORDS; k++)
         if (w == 8'(k)) r = v[32*k +: 32];
      return r;
   endfunction

   function automatic logic [31:0] cfg_word(input logic [2*NUM_IRQ-1:0] v, input logic [7:0] w);
      logic [31:0] r;
      r = '0;
      for (int k = 0; k < NUM_CFG_WORDS; k++)
         if (w == 8'(k)) r = v[32*k +: 32];
      return r;
   endfunction

   always_comb begin
      rd_data = '0;
      if (rd_addr[1:0] == 2'b00) begin
         case (rd_addr[11:10])
            REGION_PRIO: rd_data = byte_word(prio_flat, rd_addr[9:2]);
            REGION_TGT:  rd_data = byte_word(tgt_flat, rd_addr[9:2]);
            REGION_CFG:  rd_data = cfg_word(cfg_flat, rd_addr[9:2]);
            default: begin
               case (rd_addr[11:7])
                  WIN_CTRL: begin
                     if (rd_addr[6:2] == 5'd0)      rd_data = {31'b0, fwd_en};
                     else if (rd_addr[6:2] == 5'd1) rd_data = TYPE_WORD;
                  end
                  WIN_GROUP:                  rd_data = bit_word(grp_v, rd_addr[6:2]);
                  WIN_EN_SET, WIN_EN_CLR:     rd_data = bit_word(en_v, rd_addr[6:2]);
                  WIN_PEND_SET, WIN_PEND_CLR: rd_data = bit_word(pend_v, rd_addr[6:2]);
                  WIN_ACT_SET, WIN_ACT_CLR:   rd_data = bit_word(act_v, rd_addr[6:2]);
                  default:                    rd_data = '0;
               endcase
            end
         endcase
      end
   end

endmodule

// File: rtl/irq_dist_chk.sv
`timescale 1ns/1ps
module irq_dist_chk #(
   parameter int NUM_IRQ = 64,
   localparam int ID_W = $clog2(NUM_IRQ)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic               ack_valid,
   input logic [ID_W-1:0]    ack_id,
   input logic               eoi_valid,
   input logic [ID_W-1:0]    eoi_id,
   input logic               fwd_en,
   input logic [NUM_IRQ-1:0] cand_v,
   input logic [NUM_IRQ-1:0] act_v,
   input logic               best_valid,
   input logic [ID_W-1:0]    best_id
);

   logic [NUM_IRQ-1:0] cand_d;
   logic               fwd_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand_d <= '0;
         fwd_d  <= 1'b0;
      end else begin
         cand_d <= cand_v;
         fwd_d  <= fwd_en;
      end
   end

   // R7
   fwd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fwd_d |-> !best_valid);

   // R10
   winner_is_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      best_valid |-> cand_d[best_id]);

   // R10
   busy_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_d && (|cand_d)) |-> best_valid);

   // R11
   ack_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |=> act_v[$past(ack_id)]);

   // R12
   eoi_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_valid && !wr_en && !(ack_valid && ack_id == eoi_id)) |=> !act_v[$past(eoi_id)]);

endmodule

bind irq_dist_bank irq_dist_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .ack_valid  (ack_valid),
   .ack_id     (ack_id),
   .eoi_valid  (eoi_valid),
   .eoi_id     (eoi_id),
   .fwd_en     (fwd_en),
   .cand_v     (cand_v),
   .act_v      (act_v),
   .best_valid (best_valid),
   .best_id    (best_id)
);

// File: tb/tb_irq_dist_bank.sv
`timescale 1ns/1ps
module tb_irq_dist_bank;

   localparam int NUM_IRQ = 64;
   localparam int ID_W = $clog2(NUM_IRQ);

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               wr_en = 1'b0;
   logic [11:0]        wr_addr = '0;
   logic [31:0]        wr_data = '0;
   logic [11:0]        rd_addr = '0;
   logic [31:0]        rd_data;
   logic [NUM_IRQ-1:0] irq_in = '0;
   logic               ack_valid = 1'b0;
   logic [ID_W-1:0]    ack_id = '0;
   logic               eoi_valid = 1'b0;
   logic [ID_W-1:0]    eoi_id = '0;
   logic               best_valid;
   logic [ID_W-1:0]    best_id;
   logic [7:0]         best_prio;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   irq_dist_bank #(.NUM_IRQ(NUM_IRQ)) dut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .irq_in(irq_in),
      .ack_valid(ack_valid), .ack_id(ack_id),
      .eoi_valid(eoi_valid), .eoi_id(eoi_id),
      .best_valid(best_valid), .best_id(best_id), .best_prio(best_prio)
   );

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
      rd_addr = a;
      #1;
      checks++;
      if (rd_data !== exp) begin
         errors++;
         $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rd_data, exp);
      end
   endtask

   task automatic best_chk(input logic v, input int id, input logic [7:0] p, input string tag);
      @(negedge clk);
      checks++;
      if (best_valid !== v || (v && (best_id !== ID_W'(id) || best_prio !== p))) begin
         errors++;
         $display("FAIL %s actual=%b/%0d/%h expected=%b/%0d/%h",
                  tag, best_valid, best_id, best_prio, v, id, p);
      end
   endtask

   task automatic line(input int id, input logic v);
      @(negedge clk);
      irq_in[id] = v;
      @(negedge clk);
   endtask

   task automatic do_ack(input int id);
      @(negedge clk);
      ack_valid = 1'b1; ack_id = ID_W'(id);
      @(negedge clk);
      ack_valid = 1'b0;
   endtask

   task automatic do_eoi(input int id);
      @(negedge clk);
      eoi_valid = 1'b1; eoi_id = ID_W'(id);
      @(negedge clk);
      eoi_valid = 1'b0;
   endtask

   task automatic t_reset;
      rd_chk(12'h000, 32'h0, "R1 ctrl");
      rd_chk(12'h100, 32'h0, "R1 enable");
      rd_chk(12'h404, 32'h0, "R1 prio");
      rd_chk(12'hC08, 32'h0, "R1 cfg ids32+");
      rd_chk(12'hC00, 32'hAAAA_AAAA, "R5 fixed cfg at reset");
      rd_chk(12'h004, 32'h1, "R6 type");
      best_chk(1'b0, 0, 8'h0, "R1 best after reset");
   endtask

   task automatic t_enable;
      wr(12'h100, 32'h5);
      rd_chk(12'h100, 32'h5, "R2 set-enable");
      rd_chk(12'h180, 32'h5, "R2 clear window reads state");
      wr(12'h100, 32'h0);
      rd_chk(12'h100, 32'h5, "R2 zero write no effect");
      wr(12'h180, 32'h1);
      rd_chk(12'h100, 32'h4, "R2 clear-enable");
      rd_chk(12'h104, 32'h0, "R2 other word untouched");
      wr(12'h102, 32'h8);
      rd_chk(12'h100, 32'h4, "R13 misaligned write ignored");
      rd_chk(12'h101, 32'h0, "R13 misaligned read zero");
   endtask

   task automatic t_bytes;
      wr(12'h404, 32'h1122_3344);
      rd_chk(12'h404, 32'h1122_3344, "R4 priority lanes");
      wr(12'h808, 32'h0000_00A5);
      rd_chk(12'h808, 32'h0000_00A5, "R4 target lanes");
      wr(12'h080, 32'h0000_00F0);
      rd_chk(12'h080, 32'h0000_00F0, "R3 group write");
      wr(12'h080, 32'h0);
      rd_chk(12'h080, 32'h0, "R3 group plain clear");
   endtask

   task automatic t_cfg;
      wr(12'hC00, 32'h5555_5555);
      rd_chk(12'hC00, 32'hAAAA_AAAA, "R5 low ids read-only");
      wr(12'hC08, 32'h0000_0002);
      rd_chk(12'hC08, 32'h0000_0002, "R5 id32 edge");
   endtask

   task automatic t_capture;
      line(32, 1'b1);
      rd_chk(12'h204, 32'h1, "R8 edge sets pending");
      line(32, 1'b0);
      rd_chk(12'h204, 32'h1, "R8 edge pending held");
      wr(12'h284, 32'h1);
      rd_chk(12'h204, 32'h0, "R3 clear-pending");
      line(33, 1'b1);
      rd_chk(12'h204, 32'h2, "R9 level pending high");
      line(33, 1'b0);
      rd_chk(12'h204, 32'h0, "R9 level pending drops");
   endtask

   task automatic t_arb;
      wr(12'h000, 32'h1);
      rd_chk(12'h000, 32'h1, "R7 ctrl readback");
      wr(12'h104, 32'hE);
      wr(12'h420, 32'h2020_4000);
      wr(12'h204, 32'hE);
      best_chk(1'b1, 34, 8'h20, "R10 tie lowest id");
      wr(12'h000, 32'h0);
      best_chk(1'b0, 0, 8'h0, "R7 forwarding off");
      wr(12'h000, 32'h1);
      best_chk(1'b1, 34, 8'h20, "R7 forwarding on");
   endtask

   task automatic t_ack;
      do_ack(34);
      rd_chk(12'h304, 32'h4, "R11 ack sets active");
      rd_chk(12'h204, 32'hA, "R11 ack clears pending");
      best_chk(1'b1, 35, 8'h20, "R11 next candidate");
      do_eoi(34);
      rd_chk(12'h304, 32'h0, "R12 eoi clears active");
      best_chk(1'b1, 35, 8'h20, "R12 best unchanged");
      wr(12'h304, 32'h8);
      rd_chk(12'h304, 32'h8, "R3 set-active");
      best_chk(1'b1, 33, 8'h40, "R10 active excluded");
      wr(12'h384, 32'h8);
      best_chk(1'b1, 35, 8'h20, "R3 clear-active");
   endtask

   task automatic t_level_ack;
      wr(12'h424, 32'h0000_0010);
      wr(12'h104, 32'h10);
      rd_chk(12'h104, 32'h1E, "R2 enable accumulates");
      line(36, 1'b1);
      best_chk(1'b1, 36, 8'h10, "R10 lowest priority value");
      rd_chk(12'h204, 32'h1A, "R9 level pending");
      do_ack(36);
      rd_chk(12'h204, 32'h0A, "R9 acked level not pending");
      rd_chk(12'h304, 32'h10, "R11 level active");
      best_chk(1'b1, 35, 8'h20, "R11 fallback");
      do_eoi(36);
      rd_chk(12'h204, 32'h1A, "R9 repends after eoi");
      rd_chk(12'h304, 32'h0, "R12 level inactive");
      best_chk(1'b1, 36, 8'h10, "R10 returns");
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_bytes();
      t_cfg();
      t_capture();
      t_arb();
      t_ack();
      t_level_ack();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule